// File: doc/BRIEF.md
# Readout Protection Access Controller

This block guards on-chip memories against readout by untrusted agents. After reset it waits for a protection code byte from non-volatile option storage, decodes it into one of three protection levels, and from then on judges every access to main flash, system memory, option bytes, backup registers and retained SRAM. Each judgement weighs the level, the target region, the operation and the execution context: plain user execution, or a restricted context (debugger attached, boot from RAM, or bootloader selected).

The block also sequences level changes. Raising the level is committed directly. Lowering from level 1 to level 0 first opens an erase handshake with the flash controller and commits the new level only after the erase is reported done. A configuration bit loaded with the level chooses whether the execute-only code region is included in that erase. Level 2 is final: no request can lower it. Denied accesses return zero data and set an error flag that stays set until reset.

The control state machine has four states. BOOT waits for the option load and leaves on `opt_valid`. IDLE serves accesses; an accepted change request moves it to ERASE (level 1 to level 0) or to COMMIT (any raise). ERASE holds the erase request and leaves for COMMIT on `erase_done`. COMMIT writes the pending level and returns to IDLE one cycle later.

Top module: `rdp_access_ctrl`

## Requirements
- R1: After reset `prot_level` reads 2, `busy` is 1 and every access is denied until `opt_valid`. One cycle after `opt_valid` the level is loaded: code byte 0xA5 gives level 0, 0x3C gives level 2, and any other byte gives level 1. `prot_level` encodes the levels as 2'd0, 2'd1 and 2'd2.
- R2: At level 1, while any of `ctx_debug`, `ctx_ram_boot` or `ctx_loader` is high, every operation on main flash (region 0), backup registers (region 3) and retained SRAM (region 4) is denied.
- R3: At level 0 every read, write and erase on regions 0, 2, 3 and 4 is granted in any context. At level 1 in user context, all of these operations are granted on regions 0, 3 and 4. At level 1, option bytes (region 2) are granted in any context.
- R4: Region codes are 0 main flash, 1 system memory, 2 option bytes, 3 backup registers and 4 retained SRAM; codes 5 to 7 are always denied. Operation codes are 0 read, 1 write and 2 erase; code 3 is always denied. System memory grants reads only, and never grants at level 2 in a restricted context.
- R5: `aux_entry_en` is high once a level 0 or level 1 code has been loaded, and low at level 2 or before loading. At level 2 every access from a restricted context is denied, and option bytes are read-only. User-context operations on regions 0, 3 and 4 are granted.
- R6: At level 2, change requests are ignored: the level stays 2, `busy` stays 0 and no erase is requested.
- R7: A request for level 0 while at level 1 raises `erase_req` on the cycle after the request. `erase_req` is held until `erase_done` is sampled. While `erase_req` is high, `erase_xo` equals the configuration bit loaded with the level. The level reads 0 two cycles after `erase_done` is sampled and never before.
- R8: A request that raises the level (0 to 1, 0 to 2, 1 to 2) takes effect two cycles after the request, with no erase. A request whose code decodes to the current level is ignored.
- R9: Every access is answered one cycle later on `rsp_valid`. A granted read returns the `mem_rdata` presented with the request. Granted writes and erases return zero. A denied access returns `rsp_grant` 0 and zero data and sets `err_flag`, which stays high until reset.
- R10: While `busy` is high, all accesses are denied and further change requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opt_valid | input | 1 | Option storage presents the protection code (one pulse) |
| opt_level | input | 8 | Protection code byte from option storage |
| opt_erase_xo | input | 1 | Include execute-only region in downgrade erase |
| chg_req | input | 1 | Request a level change |
| chg_level | input | 8 | Requested protection code byte |
| erase_done | input | 1 | Flash controller reports erase finished |
| erase_req | output | 1 | Mass erase request, held until done |
| erase_xo | output | 1 | Erase also covers the execute-only region |
| prot_level | output | 2 | Current decoded protection level |
| busy | output | 1 | Not loaded, or a level change is in progress |
| aux_entry_en | output | 1 | Debug port, RAM boot and bootloader entry allowed |
| ctx_debug | input | 1 | Debugger attached |
| ctx_ram_boot | input | 1 | Boot from RAM selected |
| ctx_loader | input | 1 | Bootloader selected |
| acc_valid | input | 1 | Access request |
| acc_region | input | 3 | Target region code |
| acc_op | input | 2 | Operation code |
| mem_rdata | input | 32 | Memory read data accompanying the request |
| rsp_valid | output | 1 | Response valid |
| rsp_grant | output | 1 | Access granted |
| rsp_rdata | output | 32 | Read data, zero unless a granted read |
| err_flag | output | 1 | Sticky access violation flag |

## Verification
The hardest situation to reach is a downgrade with other traffic landing inside the erase window. That means accesses and competing change requests arriving while `erase_req` is held, followed by the two-step commit. The bench holds `erase_done` low for several cycles and injects an access and a level-2 request inside that window. It then checks that the level stays 1 until two cycles after the handshake, and that the ignored request leaves no trace. Random traffic over all regions, operations and context combinations is run at each level, including level codes drawn at random, so that the policy table is covered rather than sampled.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN      = 2'd0,
        LVL_READ_LOCK = 2'd1,
        LVL_CHIP_LOCK = 2'd2
    } prot_lvl_e;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ERASE  = 2'd2,
        ST_COMMIT = 2'd3
    } ctl_state_e;

    localparam int REGION_W = 3;
    localparam int OP_W     = 2;

    localparam logic [REGION_W-1:0] RG_MAIN = 3'd0;
    localparam logic [REGION_W-1:0] RG_SYS  = 3'd1;
    localparam logic [REGION_W-1:0] RG_OPT  = 3'd2;
    localparam logic [REGION_W-1:0] RG_BKP  = 3'd3;
    localparam logic [REGION_W-1:0] RG_SRAM = 3'd4;

    localparam logic [OP_W-1:0] OP_READ  = 2'd0;
    localparam logic [OP_W-1:0] OP_WRITE = 2'd1;
    localparam logic [OP_W-1:0] OP_ERASE = 2'd2;

endpackage

// File: rtl/rdp_level_fsm.sv
module rdp_level_fsm
    import rdp_pkg::*;
#(
    parameter int              LVL_W     = 8,
    parameter logic [LVL_W-1:0] OPEN_CODE = 8'hA5,
    parameter logic [LVL_W-1:0] CHIP_CODE = 8'h3C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opt_valid,
    input  logic [LVL_W-1:0] opt_level,
    input  logic             opt_erase_xo,
    input  logic             chg_req,
    input  logic [LVL_W-1:0] chg_level,
    input  logic             erase_done,
    output prot_lvl_e        level,
    output logic             busy,
    output logic             erase_req,
    output logic             erase_xo,
    output logic             aux_en
);

    function automatic prot_lvl_e decode_lvl(input logic [LVL_W-1:0] code);
        if (code == OPEN_CODE) return LVL_OPEN;
        if (code == CHIP_CODE) return LVL_CHIP_LOCK;
        return LVL_READ_LOCK;
    endfunction

    ctl_state_e state_q, state_d;
    prot_lvl_e  level_q, pend_q, req_lvl;
    logic       xo_cfg_q;
    logic       erase_ok_q;
    logic       accept;
    logic       downgrade;

    assign req_lvl   = decode_lvl(chg_level);
    assign accept    = chg_req && (level_q != LVL_CHIP_LOCK) && (req_lvl != level_q);
    assign downgrade = (level_q == LVL_READ_LOCK) && (req_lvl == LVL_OPEN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   if (opt_valid)  state_d = ST_IDLE;
            ST_IDLE:   if (accept)     state_d = downgrade ? ST_ERASE : ST_COMMIT;
            ST_ERASE:  if (erase_done) state_d = ST_COMMIT;
            ST_COMMIT:                 state_d = ST_IDLE;
        endcase
    end

    // level, pending level and erase configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q    <= LVL_CHIP_LOCK;
            pend_q     <= LVL_CHIP_LOCK;
            xo_cfg_q   <= 1'b0;
            erase_ok_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_BOOT: if (opt_valid) begin
                    level_q  <= decode_lvl(opt_level);
                    xo_cfg_q <= opt_erase_xo;
                end
                ST_IDLE: if (accept) pend_q <= req_lvl;
                ST_ERASE: if (erase_done) erase_ok_q <= 1'b1;
                ST_COMMIT: begin
                    level_q    <= pend_q;
                    erase_ok_q <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        level     = level_q;
        busy      = (state_q != ST_IDLE);
        erase_req = (state_q == ST_ERASE);
        erase_xo  = (state_q == ST_ERASE) && xo_cfg_q;
        aux_en    = (state_q != ST_BOOT) && (level_q != LVL_CHIP_LOCK);
    end

    // R6
    lvl2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BOOT && level_q == LVL_CHIP_LOCK) |=> level_q == LVL_CHIP_LOCK);

    // R7
    erase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level_q) == LVL_READ_LOCK && level_q == LVL_OPEN) |-> $past(erase_ok_q));

    // R7
    erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done) |=> erase_req);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && chg_req && !erase_done) |=> state_q == ST_ERASE);

endmodule

// File: rtl/rdp_access_check.sv
module rdp_access_check
    import rdp_pkg::*;
(
    input  prot_lvl_e             level,
    input  logic                  busy,
    input  logic                  ctx_debug,
    input  logic                  ctx_ram_boot,
    input  logic                  ctx_loader,
    input  logic [REGION_W-1:0]   region,
    input  logic [OP_W-1:0]       op,
    output logic                  allow,
    output logic                  rd_op
);

    logic restricted;
    logic wr_op;

    always_comb begin
        restricted = ctx_debug | ctx_ram_boot | ctx_loader;
        rd_op      = (op == OP_READ);
        wr_op      = (op == OP_WRITE) || (op == OP_ERASE);
        allow      = 1'b0;
        if (!busy && (rd_op || wr_op)) begin
            unique case (level)
                LVL_OPEN: begin
                    case (region)
                        RG_MAIN, RG_OPT, RG_BKP, RG_SRAM: allow = 1'b1;
                        RG_SYS:                           allow = rd_op;
                        default:                          allow = 1'b0;
                    endcase
                end
                LVL_READ_LOCK: begin
                    case (region)
                        RG_MAIN, RG_BKP, RG_SRAM: allow = !restricted;
                        RG_OPT:                   allow = 1'b1;
                        RG_SYS:                   allow = rd_op;
                        default:                  allow = 1'b0;
                    endcase
                end
                LVL_CHIP_LOCK: begin
                    if (!restricted) begin
                        case (region)
                            RG_MAIN, RG_BKP, RG_SRAM: allow = 1'b1;
                            RG_OPT, RG_SYS:           allow = rd_op;
                            default:                  allow = 1'b0;
                        endcase
                    end
                end
                default: allow = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rdp_resp.sv
module rdp_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              allow,
    input  logic              rd_op,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              err_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_rdata <= '0;
            err_flag  <= 1'b0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_grant <= acc_valid && allow;
            rsp_rdata <= (acc_valid && allow && rd_op) ? mem_rdata : '0;
            if (acc_valid && !allow) err_flag <= 1'b1;
        end
    end

    // R9
    deny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |-> rsp_rdata == '0);

    // R9
    deny_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |-> err_flag);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

// File: rtl/rdp_access_ctrl.sv
module rdp_access_ctrl
    import rdp_pkg::*;
#(
    parameter int               LVL_W     = 8,
    parameter logic [LVL_W-1:0] OPEN_CODE = 8'hA5,
    parameter logic [LVL_W-1:0] CHIP_CODE = 8'h3C,
    parameter int               DATA_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                opt_valid,
    input  logic [LVL_W-1:0]    opt_level,
    input  logic                opt_erase_xo,
    input  logic                chg_req,
    input  logic [LVL_W-1:0]    chg_level,
    input  logic                erase_done,
    output logic                erase_req,
    output logic                erase_xo,
    output logic [1:0]          prot_level,
    output logic                busy,
    output logic                aux_entry_en,
    input  logic                ctx_debug,
    input  logic                ctx_ram_boot,
    input  logic                ctx_loader,
    input  logic                acc_valid,
    input  logic [REGION_W-1:0] acc_region,
    input  logic [OP_W-1:0]     acc_op,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                rsp_valid,
    output logic                rsp_grant,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                err_flag
);

    prot_lvl_e level;
    logic      allow;
    logic      rd_op;

    rdp_level_fsm #(
        .LVL_W     (LVL_W),
        .OPEN_CODE (OPEN_CODE),
        .CHIP_CODE (CHIP_CODE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .opt_valid    (opt_valid),
        .opt_level    (opt_level),
        .opt_erase_xo (opt_erase_xo),
        .chg_req      (chg_req),
        .chg_level    (chg_level),
        .erase_done   (erase_done),
        .level        (level),
        .busy         (busy),
        .erase_req    (erase_req),
        .erase_xo     (erase_xo),
        .aux_en       (aux_entry_en)
    );

    rdp_access_check u_chk (
        .level        (level),
        .busy         (busy),
        .ctx_debug    (ctx_debug),
        .ctx_ram_boot (ctx_ram_boot),
        .ctx_loader   (ctx_loader),
        .region       (acc_region),
        .op           (acc_op),
        .allow        (allow),
        .rd_op        (rd_op)
    );

    rdp_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .allow     (allow),
        .rd_op     (rd_op),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_grant (rsp_grant),
        .rsp_rdata (rsp_rdata),
        .err_flag  (err_flag)
    );

    assign prot_level = level;

    // R2
    dbg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && level == LVL_READ_LOCK && (ctx_debug || ctx_ram_boot || ctx_loader)
         && (acc_region == RG_MAIN || acc_region == RG_BKP || acc_region == RG_SRAM))
        |=> (rsp_valid && !rsp_grant));

    // R10
    busy_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && busy) |=> (rsp_valid && !rsp_grant));

endmodule

// File: tb/tb_rdp_access_ctrl.sv
`timescale 1ns/1ps
module tb_rdp_access_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        opt_valid = 0, opt_erase_xo = 0, chg_req = 0, erase_done = 0;
    logic [7:0]  opt_level = 0, chg_level = 0;
    logic        erase_req, erase_xo, busy, aux_entry_en;
    logic [1:0]  prot_level;
    logic        ctx_debug = 0, ctx_ram_boot = 0, ctx_loader = 0, acc_valid = 0;
    logic [2:0]  acc_region = 0;
    logic [1:0]  acc_op = 0;
    logic [31:0] mem_rdata = 0, rsp_rdata;
    logic        rsp_valid, rsp_grant, err_flag;

    int  checks = 0;
    int  errors = 0;
    bit  err_m  = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    rdp_access_ctrl dut (
        .clk(clk), .rst_n(rst_n), .opt_valid(opt_valid), .opt_level(opt_level),
        .opt_erase_xo(opt_erase_xo), .chg_req(chg_req), .chg_level(chg_level),
        .erase_done(erase_done), .erase_req(erase_req), .erase_xo(erase_xo),
        .prot_level(prot_level), .busy(busy), .aux_entry_en(aux_entry_en),
        .ctx_debug(ctx_debug), .ctx_ram_boot(ctx_ram_boot), .ctx_loader(ctx_loader),
        .acc_valid(acc_valid), .acc_region(acc_region), .acc_op(acc_op),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_rdata(rsp_rdata), .err_flag(err_flag)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_allow(int lvl, bit restr, int rg, int op, bit bsy);
        if (bsy || op == 3 || rg > 4) return 0;
        if (rg == 1) return (op == 0) && !(lvl == 2 && restr);
        if (lvl == 0) return 1;
        if (lvl == 1) return (rg == 2) ? 1'b1 : !restr;
        if (restr) return 0;
        return (rg == 2) ? (op == 0) : 1'b1;
    endfunction

    function automatic string req_of(int lvl, bit restr, int rg, int op);
        if (rg == 1 || rg > 4 || op == 3) return "R4";
        if (lvl == 2) return "R5";
        if (lvl == 1 && restr) return "R2";
        return "R3";
    endfunction

    function automatic logic [7:0] lvl1_code(input logic [7:0] b);
        if (b == 8'hA5 || b == 8'h3C) return b ^ 8'h01;
        return b;
    endfunction

    task automatic do_acc(input int rg, input int op, input logic [2:0] ctx, input logic [31:0] d,
                          input int lvl, input bit bsy, input string req);
        bit ok;
        ok = model_allow(lvl, |ctx, rg, op, bsy);
        @(negedge clk);
        acc_valid = 1; acc_region = rg[2:0]; acc_op = op[1:0]; mem_rdata = d;
        ctx_debug = ctx[0]; ctx_ram_boot = ctx[1]; ctx_loader = ctx[2];
        @(negedge clk);
        acc_valid = 0; ctx_debug = 0; ctx_ram_boot = 0; ctx_loader = 0;
        if (!ok) err_m = 1;
        chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(req, "rsp_grant", 32'(rsp_grant), 32'(ok));
        chk("R9", "rsp_rdata", rsp_rdata, (ok && op == 0) ? d : 32'd0);
        chk("R9", "err_flag", 32'(err_flag), 32'(err_m));
    endtask

    task automatic rand_acc(input int n, input int lvl);
        for (int i = 0; i < n; i++) begin
            int rg, op;
            logic [2:0] ctx;
            rg  = int'($urandom_range(0, 7));
            op  = int'($urandom_range(0, 3));
            ctx = ($urandom_range(0, 1) == 0) ? 3'b000 : 3'($urandom);
            do_acc(rg, op, ctx, $urandom, lvl, 1'b0, req_of(lvl, |ctx, rg, op));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        err_m = 0;
        @(negedge clk);
    endtask

    task automatic load(input logic [7:0] code, input bit xo);
        @(negedge clk);
        opt_valid = 1; opt_level = code; opt_erase_xo = xo;
        @(negedge clk);
        opt_valid = 0;
    endtask

    task automatic change(input logic [7:0] code);
        @(negedge clk);
        chg_req = 1; chg_level = code;
        @(negedge clk);
        chg_req = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        chk("R1", "reset level", 32'(prot_level), 32'd2);
        chk("R1", "reset busy", 32'(busy), 32'd1);
        chk("R5", "reset aux", 32'(aux_entry_en), 32'd0);
        chk("R7", "reset erase_req", 32'(erase_req), 32'd0);
        chk("R9", "reset err", 32'(err_flag), 32'd0);

        // R1 level 0 load
        load(8'hA5, 1'b1);
        chk("R1", "load A5", 32'(prot_level), 32'd0);
        chk("R5", "aux at L0", 32'(aux_entry_en), 32'd1);
        do_acc(0, 0, 3'b001, 32'hDEAD_BEEF, 0, 1'b0, "R3");
        do_acc(3, 1, 3'b000, 32'h1234_5678, 0, 1'b0, "R9");
        rand_acc(150, 0);

        // R8 raise 0 -> 1
        change(8'h77);
        chk("R8", "raise busy", 32'(busy), 32'd1);
        chk("R8", "raise no erase", 32'(erase_req), 32'd0);
        @(negedge clk);
        chk("R8", "raise level", 32'(prot_level), 32'd1);
        chk("R8", "raise done", 32'(busy), 32'd0);
        // R8 same-level code ignored
        change(8'h12);
        chk("R8", "same-level busy", 32'(busy), 32'd0);
        chk("R8", "same-level level", 32'(prot_level), 32'd1);
        do_acc(0, 2, 3'b010, 32'h0, 1, 1'b0, "R2");
        rand_acc(150, 1);

        // R7 downgrade 1 -> 0 with traffic in the window
        change(8'hA5);
        chk("R7", "erase_req", 32'(erase_req), 32'd1);
        chk("R7", "erase_xo", 32'(erase_xo), 32'd1);
        do_acc(0, 0, 3'b000, 32'hAAAA_5555, 1, 1'b1, "R10");
        change(8'h3C);
        repeat (3) @(negedge clk);
        chk("R7", "held erase_req", 32'(erase_req), 32'd1);
        chk("R7", "level during erase", 32'(prot_level), 32'd1);
        erase_done = 1;
        @(negedge clk);
        erase_done = 0;
        chk("R7", "erase released", 32'(erase_req), 32'd0);
        chk("R7", "level at commit", 32'(prot_level), 32'd1);
        @(negedge clk);
        chk("R7", "level after erase", 32'(prot_level), 32'd0);
        chk("R10", "ignored request left no trace", 32'(busy), 32'd0);

        // R8 raise 0 -> 2, then R6
        change(8'h3C);
        @(negedge clk);
        chk("R8", "raise to 2", 32'(prot_level), 32'd2);
        chk("R5", "aux at L2", 32'(aux_entry_en), 32'd0);
        change(8'hA5);
        chk("R6", "no erase at L2", 32'(erase_req), 32'd0);
        chk("R6", "no busy at L2", 32'(busy), 32'd0);
        change(8'h55);
        repeat (3) @(negedge clk);
        chk("R6", "level stays 2", 32'(prot_level), 32'd2);
        do_acc(2, 1, 3'b000, 32'h0, 2, 1'b0, "R5");
        do_acc(0, 0, 3'b100, 32'h9, 2, 1'b0, "R5");
        rand_acc(150, 2);

        // R1 access before load, random level-1 codes, xo bit clear
        for (int k = 0; k < 4; k++) begin
            logic [7:0] code;
            code = lvl1_code(8'($urandom));
            do_reset();
            do_acc(4, 0, 3'b000, 32'h7, 2, 1'b1, "R1");
            load(code, 1'b0);
            chk("R1", "random code level", 32'(prot_level), 32'd1);
            rand_acc(60, 1);
        end
        change(8'hA5);
        chk("R7", "erase_xo clear", 32'(erase_xo), 32'd0);
        erase_done = 1;
        @(negedge clk);
        erase_done = 0;
        @(negedge clk);
        chk("R7", "second downgrade", 32'(prot_level), 32'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule